// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block runs the element loop of one vector operation under a per-element predicate mask. A single start pulse captures the operating mode, the vector length and the current mask. The block then presents element indices one at a time on an issue stream, each with a write-enable for the downstream datapath. When the last element has been accepted, a one-cycle done pulse follows. The arithmetic and the register storage sit elsewhere. This block only decides which elements are issued and whether each one may write its result.

Two modes are chosen per operation. In the full-scan mode every index below the vector length is issued in turn, and the write-enable carries that element's mask bit, so a masked-off element passes through the pipe without changing its destination. In the density-time mode the block skips elements whose mask bit is clear. The operation therefore takes as many issue cycles as there are active elements. The mask register lives in this block. It can be filled with ones, loaded from a signed greater-than-zero test across all elements, or written directly. It can be read at any time.

The issue stream is valid/ready. While `iss_valid` is high and `iss_ready` is low, the index and write-enable are held and nothing advances. The consumer may stall for any number of cycles. `iss_valid` never depends combinationally on `iss_ready`.

Top module: `elem_pred_seq`

## Requirements
- R1: A set-all command (`mask_set_all` high at a clock edge) makes every bit of `mask_q` one from the next cycle, enabling all elements.
- R2: A compare command (`cmp_en`) writes bit i of the mask to one when element i of `cmp_elems`, taken as a two's-complement value from bits [i*EW +: EW], is greater than zero, and to zero otherwise (zero and negative values give zero).
- R3: Mask commands take effect on the next cycle at any time, including during a run, with priority set-all over compare over direct write (`mask_wr_en`/`mask_wr_data`).
- R4: In full-scan mode (`cfg_dense` = 0), indices 0 up to length-1 are each issued once, in ascending order, and `iss_we` equals the captured mask bit of that index.
- R5: In density-time mode (`cfg_dense` = 1), only indices below the length whose captured mask bit is one are issued, in ascending order, each with `iss_we` = 1, at most one per cycle.
- R6: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_idx` and `iss_we` keep their values on the next cycle. An element is consumed only on a cycle with both high.
- R7: `done` is high for exactly one cycle: the cycle after the final element is accepted. A density-time run with no active element below the length issues nothing and raises `done` in the cycle after the start edge.
- R8: Mode, length and mask are captured on the start edge, and the mask used is the value held before any same-edge mask command. Later changes to `cfg_dense`, `cfg_len` or the mask do not affect the run in progress.
- R9: `busy` is high from the cycle after an accepted start until the cycle that carries `done`. A start while `busy` is high is ignored.
- R10: A `cfg_len` of 0 acts as 1 and a value above VLEN acts as VLEN. Mask bits at or above the effective length are never issued in density-time mode and never reach `iss_idx` in either mode.
- R11: After reset `iss_valid`, `busy` and `done` are low and `mask_q` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| cfg_dense | input | 1 | 1 = density-time, 0 = full-scan |
| cfg_len | input | LEN_W | Requested vector length |
| mask_set_all | input | 1 | Fill the mask with ones |
| cmp_en | input | 1 | Load mask from signed greater-than-zero test |
| cmp_elems | input | VLEN*EW | Packed element values for the compare |
| mask_wr_en | input | 1 | Direct mask write strobe |
| mask_wr_data | input | VLEN | Direct mask write value |
| mask_q | output | VLEN | Current mask register |
| iss_valid | output | 1 | Issue stream valid |
| iss_ready | input | 1 | Issue stream ready from consumer |
| iss_idx | output | IDX_W | Element index being issued |
| iss_we | output | 1 | Result write-enable for the issued element |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a mask command that lands on the same edge as the start, together with a consumer stall on the last element of a density-time run. There the captured mask, the live register and the done timing can all diverge. The bench drives a direct mask write in the start cycle, and in the following cycles it writes again and changes the mode and length inputs. A pseudo-random ready pattern stalls the consumer for several cycles at a time. The reference model tracks pending elements as a queue, so each of these situations is checked against it on every cycle.

// File: rtl/elem_pred_pkg.sv
package elem_pred_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic [1:0] {
    MC_NONE  = 2'd0,
    MC_FILL  = 2'd1,
    MC_TEST  = 2'd2,
    MC_WRITE = 2'd3
  } mask_cmd_e;

endpackage

// File: rtl/epq_mask_bank.sv
module epq_mask_bank
  import elem_pred_pkg::*;
#(
  parameter int VLEN = 8,
  parameter int EW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_all,
  input  logic                 test_en,
  input  logic [VLEN*EW-1:0]   test_elems,
  input  logic                 wr_en,
  input  logic [VLEN-1:0]      wr_data,
  output logic [VLEN-1:0]      mask_q
);

  logic [VLEN-1:0] gt_zero;
  mask_cmd_e       cmd;
  logic [VLEN-1:0] mask_d;

  // One signed comparator per element lane.
  for (genvar g = 0; g < VLEN; g++) begin : g_lane
    logic signed [EW-1:0] lane_val;
    assign lane_val   = test_elems[g*EW +: EW];
    assign gt_zero[g] = (lane_val > 0);
  end

  // Command decode with fixed priority.
  always_comb begin
    if (fill_all)     cmd = MC_FILL;
    else if (test_en) cmd = MC_TEST;
    else if (wr_en)   cmd = MC_WRITE;
    else              cmd = MC_NONE;
  end

  always_comb begin
    unique case (cmd)
      MC_FILL:  mask_d = '1;
      MC_TEST:  mask_d = gt_zero;
      MC_WRITE: mask_d = wr_data;
      default:  mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    fill_all |=> (mask_q == '1)); // R1

  AST_TEST_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !fill_all) |=> (mask_q[0] == ($past($signed(test_elems[EW-1:0])) > 0))); // R2

  AST_WRITE_LOW_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !test_en && !fill_all) |=> (mask_q == $past(wr_data))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !test_en && !fill_all) |=> $stable(mask_q)); // R3

endmodule

// File: rtl/epq_first_set.sv
module epq_first_set #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/epq_issue_ctrl.sv
module epq_issue_ctrl
  import elem_pred_pkg::*;
#(
  parameter int VLEN  = 8,
  parameter int LEN_W = $clog2(VLEN + 1),
  parameter int IDX_W = (VLEN > 1) ? $clog2(VLEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dense,
  input  logic [LEN_W-1:0] len_eff,
  input  logic [VLEN-1:0]  len_mask,
  input  logic [VLEN-1:0]  mask_now,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [IDX_W-1:0] iss_idx,
  output logic             iss_we,
  output logic             busy,
  output logic             done
);

  seq_state_e       state_q;
  logic [VLEN-1:0]  snap_q;
  logic [VLEN-1:0]  pend_q;
  logic             dense_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;

  logic [VLEN-1:0]  pend_init;
  logic [VLEN-1:0]  pend_after;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic             take;
  logic             accept;

  epq_first_set #(.W(VLEN), .IDX_W(IDX_W)) u_pick (
    .vec (pend_q),
    .idx (pick_idx),
    .any (pick_any)
  );

  // Full-scan walks every index below length; density-time only set ones.
  assign pend_init = dense ? (mask_now & len_mask) : len_mask;

  assign iss_valid = (state_q == SQ_RUN) && pick_any;
  assign iss_idx   = pick_idx;
  assign iss_we    = snap_q[pick_idx];
  assign take      = iss_valid && iss_ready;
  assign accept    = (state_q == SQ_IDLE) && start;

  always_comb begin
    pend_after = pend_q;
    if (take) pend_after[pick_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      snap_q  <= '0;
      pend_q  <= '0;
      dense_q <= 1'b0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (accept) begin
            snap_q  <= mask_now;
            dense_q <= dense;
            len_q   <= len_eff;
            pend_q  <= pend_init;
            if (pend_init == '0) done_q  <= 1'b1;
            else                 state_q <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          pend_q <= pend_after;
          if (take && (pend_after == '0)) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q == SQ_RUN);
  assign done = done_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_idx) && $stable(iss_we))); // R6

  AST_DENSE_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dense_q) |-> iss_we); // R5

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!iss_valid || (iss_idx > $past(iss_idx)))); // R4

  AST_IDX_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (LEN_W'(iss_idx) < len_q)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !iss_valid)); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(snap_q) && $stable(dense_q) && $stable(len_q))); // R9

  AST_RUN_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> iss_valid); // R7

endmodule

// File: rtl/elem_pred_seq.sv
module elem_pred_seq
  import elem_pred_pkg::*;
#(
  parameter int VLEN  = 8,
  parameter int EW    = 16,
  parameter int LEN_W = $clog2(VLEN + 1),
  parameter int IDX_W = (VLEN > 1) ? $clog2(VLEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_dense,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               mask_set_all,
  input  logic               cmp_en,
  input  logic [VLEN*EW-1:0] cmp_elems,
  input  logic               mask_wr_en,
  input  logic [VLEN-1:0]    mask_wr_data,
  output logic [VLEN-1:0]    mask_q,
  output logic               iss_valid,
  input  logic               iss_ready,
  output logic [IDX_W-1:0]   iss_idx,
  output logic               iss_we,
  output logic               busy,
  output logic               done
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(VLEN);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(1);

  logic [LEN_W-1:0] len_eff;
  logic [VLEN-1:0]  len_mask;

  // Clamp the requested length into 1..VLEN.
  always_comb begin
    if (cfg_len == '0)         len_eff = LEN_MIN;
    else if (cfg_len > LEN_MAX) len_eff = LEN_MAX;
    else                       len_eff = cfg_len;
  end

  for (genvar g = 0; g < VLEN; g++) begin : g_lenmask
    assign len_mask[g] = (LEN_W'(g) < len_eff);
  end

  epq_mask_bank #(.VLEN(VLEN), .EW(EW)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_all   (mask_set_all),
    .test_en    (cmp_en),
    .test_elems (cmp_elems),
    .wr_en      (mask_wr_en),
    .wr_data    (mask_wr_data),
    .mask_q     (mask_q)
  );

  epq_issue_ctrl #(.VLEN(VLEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dense     (cfg_dense),
    .len_eff   (len_eff),
    .len_mask  (len_mask),
    .mask_now  (mask_q),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_idx   (iss_idx),
    .iss_we    (iss_we),
    .busy      (busy),
    .done      (done)
  );

  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (len_eff >= LEN_MIN) && (len_eff <= LEN_MAX)); // R10

endmodule

// File: tb/elem_pred_seq_tb.sv
module elem_pred_seq_tb_top;
  localparam int VLEN  = 8;
  localparam int EW    = 16;
  localparam int LEN_W = 4;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n;
  logic               start;
  logic               cfg_dense;
  logic [LEN_W-1:0]   cfg_len;
  logic               mask_set_all;
  logic               cmp_en;
  logic [VLEN*EW-1:0] cmp_elems;
  logic               mask_wr_en;
  logic [VLEN-1:0]    mask_wr_data;
  logic [VLEN-1:0]    mask_q;
  logic               iss_valid;
  logic               iss_ready;
  logic [IDX_W-1:0]   iss_idx;
  logic               iss_we;
  logic               busy;
  logic               done;

  elem_pred_seq #(.VLEN(VLEN), .EW(EW), .LEN_W(LEN_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_dense(cfg_dense), .cfg_len(cfg_len),
    .mask_set_all(mask_set_all), .cmp_en(cmp_en), .cmp_elems(cmp_elems),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_q(mask_q),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_idx(iss_idx), .iss_we(iss_we),
    .busy(busy), .done(done)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string tag   = "R11";
  bit    live  = 1'b0;
  bit    rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // Behavioural reference model
  bit [VLEN-1:0] m_mask;
  bit            m_busy;
  bit            m_done;
  int            q_idx[$];
  bit            q_we[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '1; m_busy = 0; m_done = 0;
      q_idx.delete(); q_we.delete();
    end else begin
      bit nd;
      bit [VLEN-1:0] nm;
      nd = 0;
      if (m_busy) begin
        if (iss_ready) begin
          void'(q_idx.pop_front());
          void'(q_we.pop_front());
          if (q_idx.size() == 0) begin m_busy = 0; nd = 1; end
        end
      end else if (start) begin
        int len;
        len = (cfg_len == 0) ? 1 : ((int'(cfg_len) > VLEN) ? VLEN : int'(cfg_len));
        for (int i = 0; i < len; i++) begin
          if (!cfg_dense) begin q_idx.push_back(i); q_we.push_back(m_mask[i]); end
          else if (m_mask[i]) begin q_idx.push_back(i); q_we.push_back(1'b1); end
        end
        if (q_idx.size() == 0) nd = 1; else m_busy = 1;
      end
      nm = m_mask;
      if (mask_set_all) nm = '1;
      else if (cmp_en) begin
        for (int i = 0; i < VLEN; i++) nm[i] = ($signed(cmp_elems[i*EW +: EW]) > 0);
      end else if (mask_wr_en) nm = mask_wr_data;
      m_mask = nm;
      m_done = nd;
      live   = 1'b1;
    end
  end

  task automatic check(string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, sig, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && live) begin
      check("mask_q", int'(mask_q), int'(m_mask));
      check("iss_valid", int'(iss_valid), int'(m_busy));
      check("busy", int'(busy), int'(m_busy));
      check("done", int'(done), int'(m_done));
      if (m_busy) begin
        check("iss_idx", int'(iss_idx), q_idx[0]);
        check("iss_we", int'(iss_we), int'(q_we[0]));
      end
    end
  end

  always @(negedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    iss_ready = rdy_rand ? (lfsr[0] & lfsr[3]) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic go(bit dense, int len);
    step(1);
    cfg_dense = dense; cfg_len = LEN_W'(len); start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  task automatic wr_mask(logic [VLEN-1:0] v);
    step(1);
    mask_wr_en = 1'b1; mask_wr_data = v;
    step(1);
    mask_wr_en = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 400 && (m_busy || m_done); k++) step(1);
    step(2);
  endtask

  task automatic set_elem(int i, int v);
    cmp_elems[i*EW +: EW] = EW'(v);
  endtask

  initial begin
    rst_n = 0; start = 0; cfg_dense = 0; cfg_len = 8;
    mask_set_all = 0; cmp_en = 0; cmp_elems = '0;
    mask_wr_en = 0; mask_wr_data = '0; iss_ready = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    tag = "R11"; // reset state
    step(1);
    check("reset iss_valid", int'(iss_valid), 0);
    check("reset mask_q", int'(mask_q), 255);
    step(2);

    tag = "R2"; // signed compare: positive, zero, negative, extremes
    step(1);
    set_elem(0, 5); set_elem(1, 0); set_elem(2, -1); set_elem(3, 32767);
    set_elem(4, -32768); set_elem(5, 1); set_elem(6, 0); set_elem(7, 100);
    cmp_en = 1; step(1); cmp_en = 0; step(2);
    check("R2 mask", int'(mask_q), 8'b1010_1001);

    tag = "R1";
    step(1); mask_set_all = 1; step(1); mask_set_all = 0; step(1);
    check("R1 mask", int'(mask_q), 255);

    tag = "R3"; // priorities
    step(1); mask_set_all = 1; cmp_en = 1; mask_wr_en = 1; mask_wr_data = 8'h0F;
    step(1); mask_set_all = 0; step(1); cmp_en = 0; step(1); mask_wr_en = 0; step(2);

    tag = "R4"; // full-scan
    wr_mask(8'b1011_0010); go(0, 8); settle();
    wr_mask(8'b0000_0000); go(0, 5); settle();

    tag = "R5"; // density-time
    wr_mask(8'b1011_0010); go(1, 8); settle();
    wr_mask(8'b1111_1111); go(1, 8); settle();
    wr_mask(8'b1000_0001); go(1, 8); settle();

    tag = "R6"; // back-pressure
    rdy_rand = 1;
    wr_mask(8'b1011_0110); go(1, 8); settle();
    go(0, 7); settle();
    wr_mask(8'b1000_0000); go(1, 8); settle();
    rdy_rand = 0;

    tag = "R7"; // empty density-time run
    wr_mask(8'b0000_0000); go(1, 8); settle();
    wr_mask(8'b0000_0001); go(1, 1); settle();

    tag = "R8"; // same-edge write and mid-run changes
    wr_mask(8'b0101_0101);
    step(1); cfg_dense = 1; cfg_len = 8; start = 1; mask_wr_en = 1; mask_wr_data = 8'hFF;
    step(1); start = 0; mask_wr_en = 0; cfg_dense = 0; cfg_len = 2;
    mask_set_all = 1; step(1); mask_set_all = 0;
    settle();

    tag = "R9"; // start while busy
    rdy_rand = 1;
    wr_mask(8'b1100_1100); go(1, 8);
    step(1); start = 1; cfg_dense = 0; cfg_len = 3; step(2); start = 0;
    settle();
    rdy_rand = 0;

    tag = "R10"; // length clamping and out-of-range mask bits
    wr_mask(8'b1111_0000); go(1, 4); settle();
    wr_mask(8'b1010_1010); go(0, 0); settle();
    go(1, 0); settle();
    go(0, 13); settle();
    go(1, 15); settle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule